// File: doc/BRIEF.md
# CPU Interrupt and Reset Entry Sequencer

This block is the control logic that lets a small 8-bit processor core with a 16-bit address bus break out of normal instruction flow. It watches an active-low reset pin, an active-low non-maskable request, an active-low maskable request and a ready pin. It also receives an instruction-boundary strobe and the interrupt-disable flag from the core. When an entry is due, it takes over the bus. It runs a fixed seven-cycle entry: two dummy reads at the return address, three stack cycles, and two vector reads. It then hands the core a new program counter, a new stack pointer and a request to set the interrupt-disable flag.

The core holds `pc_in`, `status_in` and `sp_in` at their current values and watches `seq_active`. While `seq_active` is high, the sequencer owns the address, data, read/write and bus-enable outputs. A reset pin held low lets the machine run on for a short grace period. After that the machine parks with the bus floated. When the pin is released, the same seven-cycle path runs as an initialisation pass whose stack cycles are reads.

The state machine has states IDLE, DUMMY1, DUMMY2, PUSH_H, PUSH_L, PUSH_P, VEC_L, VEC_H and HALT. Its transitions are as follows:
- IDLE goes to DUMMY1 on a boundary with a request.
- DUMMY1 goes to DUMMY2, then PUSH_H, PUSH_L, PUSH_P, VEC_L and VEC_H in order. Each read state waits for ready.
- VEC_H goes back to IDLE.
- Any state goes to HALT at the end of the reset grace period.
- HALT goes to DUMMY1 when the reset pin is high.

Top module: `cpu_irq_sequencer`

## Requirements
- R1: An entry takes exactly seven bus cycles when ready is held high. In the seventh cycle `pc_load` is 1 and `pc_out` is {high vector byte, low vector byte}. On the next clock, `seq_active` returns to 0.
- R2: An entry starts only on a clock edge where `insn_done` is 1 in IDLE. A request with `insn_done` low leaves the block idle.
- R3: The maskable request (`irq_n` low) is a level. It starts an entry at every boundary while it is low and `i_flag` is 0. When `i_flag` is 1, it is ignored.
- R4: The non-maskable request gives one entry per falling level. It is armed only after `nmi_n` has been sampled high on at least two consecutive edges. A single high sample does not re-arm it.
- R5: When both requests are due at one boundary, the non-maskable entry (vector 0xFFFA) runs first. A maskable request that is still low is taken at the next boundary (vector 0xFFFE).
- R6: While `res_n` is low, the block keeps running for one more clock edge. From the second consecutive low edge onward, `bus_oe` is 0 and `halted` is 1.
- R7: When `res_n` is released, the block runs the seven-cycle path with `rw` = 1 in all cycles. It reads the vector at 0xFFFC/0xFFFD and loads `sp_out` = `sp_in` − 3.
- R8: When `rdy` is 0, a read cycle (`rw` = 1) holds its address and state. A write cycle (`rw` = 0) advances whatever `rdy` is.
- R9: A maskable or non-maskable entry writes, in order, the PC high byte, the PC low byte and `status_in`. The addresses are {0x01, sp}, {0x01, sp−1} and {0x01, sp−2}. The vector low byte is read before the high byte. `sp_load` and `set_i` pulse together with `pc_load`.
- R10: After `arst_n` has been low while `res_n` is low, the block is in HALT: `halted` = 1 and `bus_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Power-on reset, active low |
| res_n | input | 1 | Reset pin, active low |
| nmi_n | input | 1 | Non-maskable request, active low |
| irq_n | input | 1 | Maskable request, active low level |
| rdy | input | 1 | Ready; 0 stalls read cycles |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| i_flag | input | 1 | Interrupt-disable flag from the core |
| pc_in | input | 16 | Current return address |
| status_in | input | 8 | Status byte to save |
| sp_in | input | 8 | Stack pointer at entry |
| data_in | input | 8 | Read data bus |
| addr | output | 16 | Address bus request |
| dout | output | 8 | Write data |
| rw | output | 1 | 1 = read, 0 = write |
| bus_oe | output | 1 | 1 = drive address/data, 0 = high impedance |
| seq_active | output | 1 | Sequencer owns the bus |
| halted | output | 1 | Parked in reset |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load `pc_out` into the core |
| sp_out | output | 8 | New stack pointer |
| sp_load | output | 1 | Load `sp_out` into the core |
| set_i | output | 1 | Set the interrupt-disable flag |

## Verification
The assertions assume that the core keeps `pc_in` unchanged for the whole of an entry. Without that, the check that a stalled read holds its address would be unfounded. They also assume that every input changes away from the rising clock edge. The stimulus meets both conditions: it changes inputs only on falling edges, and it sets the return address, status byte and stack pointer before the entry edge and leaves them alone until the entry finishes. The sweeps cover every pattern of ready stalls over the seven cycles for each of the three entry kinds, with stack pointers that wrap through zero.

// File: rtl/cpu_irq_seq_pkg.sv
package cpu_irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DUMMY1,
        ST_DUMMY2,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H,
        ST_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_IRQ,
        SRC_NMI,
        SRC_RESET
    } entry_src_t;

endpackage

// File: rtl/irqseq_reset_gate.sv
module irqseq_reset_gate #(
    parameter int GRACE = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic res_n,
    output logic halt_now
);
    localparam int CW = $clog2(GRACE + 1);

    logic [CW-1:0] low_cnt;

    // consecutive low samples of the reset pin, saturating at GRACE
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt <= CW'(GRACE);
        end else if (res_n) begin
            low_cnt <= '0;
        end else if (low_cnt < CW'(GRACE)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign halt_now = !res_n && (low_cnt >= CW'(GRACE - 1));

endmodule

// File: rtl/irqseq_nmi_latch.sv
module irqseq_nmi_latch #(
    parameter int REARM = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pend
);
    localparam int CW = $clog2(REARM + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hi_cnt <= '0;
            pend   <= 1'b0;
        end else begin
            if (nmi_n) begin
                if (hi_cnt < CW'(REARM)) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
            end

            if (!nmi_n && (hi_cnt >= CW'(REARM))) begin
                pend <= 1'b1;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqseq_fsm.sv
module irqseq_fsm
    import cpu_irq_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int STACK_PAGE = 1
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              halt_now,
    input  logic              res_n,
    input  logic              rdy,
    input  logic              insn_done,
    input  logic              nmi_pend,
    input  logic              irq_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              nmi_take,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              rw,
    output logic              bus_oe,
    output logic              seq_active,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_load,
    output logic [DATA_W-1:0] sp_out,
    output logic              sp_load,
    output logic              set_i
);
    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] VEC_IRQ_A = {ADDR_W{1'b1}} - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] VEC_RES_A = {ADDR_W{1'b1}} - ADDR_W'(3);
    localparam logic [ADDR_W-1:0] VEC_NMI_A = {ADDR_W{1'b1}} - ADDR_W'(5);

    seq_state_t        state_q, state_d;
    entry_src_t        src_q, src_d;
    logic [DATA_W-1:0] sp_q, sp_d;
    logic [DATA_W-1:0] vlo_q, vlo_d;

    logic              is_reset;
    logic              push_go;
    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] vec_base;

    assign is_reset   = (src_q == SRC_RESET);
    assign push_go    = rdy || !is_reset;
    assign stack_addr = {PAGE_W'(STACK_PAGE), sp_q};

    always_comb begin
        unique case (src_q)
            SRC_NMI:   vec_base = VEC_NMI_A;
            SRC_RESET: vec_base = VEC_RES_A;
            default:   vec_base = VEC_IRQ_A;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HALT;
            src_q   <= SRC_RESET;
            sp_q    <= '0;
            vlo_q   <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            sp_q    <= sp_d;
            vlo_q   <= vlo_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        src_d    = src_q;
        sp_d     = sp_q;
        vlo_d    = vlo_q;
        nmi_take = 1'b0;
        if (halt_now) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (insn_done && (nmi_pend || irq_req)) begin
                        state_d  = ST_DUMMY1;
                        sp_d     = sp_in;
                        src_d    = nmi_pend ? SRC_NMI : SRC_IRQ;
                        nmi_take = nmi_pend;
                    end
                end
                ST_HALT: begin
                    if (res_n) begin
                        state_d = ST_DUMMY1;
                        src_d   = SRC_RESET;
                        sp_d    = sp_in;
                    end
                end
                ST_DUMMY1: if (rdy) state_d = ST_DUMMY2;
                ST_DUMMY2: if (rdy) state_d = ST_PUSH_H;
                ST_PUSH_H: begin
                    if (push_go) begin
                        state_d = ST_PUSH_L;
                        sp_d    = sp_q - 1'b1;
                    end
                end
                ST_PUSH_L: begin
                    if (push_go) begin
                        state_d = ST_PUSH_P;
                        sp_d    = sp_q - 1'b1;
                    end
                end
                ST_PUSH_P: begin
                    if (push_go) begin
                        state_d = ST_VEC_L;
                        sp_d    = sp_q - 1'b1;
                    end
                end
                ST_VEC_L: begin
                    if (rdy) begin
                        state_d = ST_VEC_H;
                        vlo_d   = data_in;
                    end
                end
                ST_VEC_H: if (rdy) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        addr       = pc_in;
        dout       = '0;
        rw         = 1'b1;
        bus_oe     = 1'b1;
        seq_active = 1'b1;
        halted     = 1'b0;
        pc_load    = 1'b0;
        sp_load    = 1'b0;
        set_i      = 1'b0;
        pc_out     = ADDR_W'({data_in, vlo_q});
        sp_out     = sp_q;
        unique case (state_q)
            ST_IDLE: seq_active = 1'b0;
            ST_HALT: begin
                bus_oe = 1'b0;
                halted = 1'b1;
                addr   = '0;
            end
            ST_DUMMY1, ST_DUMMY2: addr = pc_in;
            ST_PUSH_H: begin
                addr = stack_addr;
                dout = DATA_W'(pc_in[ADDR_W-1:DATA_W]);
                rw   = is_reset;
            end
            ST_PUSH_L: begin
                addr = stack_addr;
                dout = pc_in[DATA_W-1:0];
                rw   = is_reset;
            end
            ST_PUSH_P: begin
                addr = stack_addr;
                dout = status_in;
                rw   = is_reset;
            end
            ST_VEC_L: addr = vec_base;
            ST_VEC_H: begin
                addr    = vec_base | ADDR_W'(1);
                pc_load = rdy;
                sp_load = rdy;
                set_i   = rdy;
            end
            default: seq_active = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu_irq_sequencer.sv
module cpu_irq_sequencer
    import cpu_irq_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int STACK_PAGE  = 1,
    parameter int RESET_GRACE = 2,
    parameter int NMI_REARM   = 2
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              res_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              rdy,
    input  logic              insn_done,
    input  logic              i_flag,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              rw,
    output logic              bus_oe,
    output logic              seq_active,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_load,
    output logic [DATA_W-1:0] sp_out,
    output logic              sp_load,
    output logic              set_i
);
    logic halt_now;
    logic nmi_pend;
    logic nmi_take;
    logic irq_req;

    assign irq_req = !irq_n && !i_flag;

    irqseq_reset_gate #(.GRACE(RESET_GRACE)) u_gate (
        .clk      (clk),
        .arst_n   (arst_n),
        .res_n    (res_n),
        .halt_now (halt_now)
    );

    irqseq_nmi_latch #(.REARM(NMI_REARM)) u_nmi (
        .clk    (clk),
        .arst_n (arst_n),
        .nmi_n  (nmi_n),
        .take   (nmi_take),
        .pend   (nmi_pend)
    );

    irqseq_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE)
    ) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .halt_now   (halt_now),
        .res_n      (res_n),
        .rdy        (rdy),
        .insn_done  (insn_done),
        .nmi_pend   (nmi_pend),
        .irq_req    (irq_req),
        .pc_in      (pc_in),
        .status_in  (status_in),
        .sp_in      (sp_in),
        .data_in    (data_in),
        .nmi_take   (nmi_take),
        .addr       (addr),
        .dout       (dout),
        .rw         (rw),
        .bus_oe     (bus_oe),
        .seq_active (seq_active),
        .halted     (halted),
        .pc_out     (pc_out),
        .pc_load    (pc_load),
        .sp_out     (sp_out),
        .sp_load    (sp_load),
        .set_i      (set_i)
    );

endmodule

// File: rtl/cpu_irq_seq_checker.sv
module cpu_irq_seq_checker #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int STACK_PAGE  = 1,
    parameter int RESET_GRACE = 2
) (
    input logic              clk,
    input logic              arst_n,
    input logic              res_n,
    input logic              rdy,
    input logic [ADDR_W-1:0] addr,
    input logic              rw,
    input logic              bus_oe,
    input logic              seq_active,
    input logic              halted,
    input logic              pc_load
);
    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam int CW     = $clog2(RESET_GRACE + 1);

    logic [CW-1:0] low_run;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_run <= CW'(RESET_GRACE);
        end else if (res_n) begin
            low_run <= '0;
        end else if (low_run < CW'(RESET_GRACE)) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_float_after_grace_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (!res_n && (low_run >= CW'(RESET_GRACE - 1))) |=> (!bus_oe && halted));

    p_read_stall_holds_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (seq_active && !halted && rw && !rdy && res_n) |=> $stable(addr));

    p_write_advances_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (seq_active && bus_oe && !rw) |=> (addr != $past(addr)));

    p_write_on_stack_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (bus_oe && !rw) |-> (seq_active && (addr[ADDR_W-1:DATA_W] == PAGE_W'(STACK_PAGE))));

    p_idle_after_load_r1: assert property (@(posedge clk) disable iff (!arst_n)
        (pc_load && res_n) |=> !seq_active);

endmodule

bind cpu_irq_sequencer cpu_irq_seq_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STACK_PAGE  (STACK_PAGE),
    .RESET_GRACE (RESET_GRACE)
) u_chk (
    .clk        (clk),
    .arst_n     (arst_n),
    .res_n      (res_n),
    .rdy        (rdy),
    .addr       (addr),
    .rw         (rw),
    .bus_oe     (bus_oe),
    .seq_active (seq_active),
    .halted     (halted),
    .pc_load    (pc_load)
);

// File: tb/tb_cpu_irq_sequencer.sv
`timescale 1ns/1ps
module tb_cpu_irq_sequencer;

    logic        clk = 1'b0;
    logic        arst_n, res_n, nmi_n, irq_n, rdy, insn_done, i_flag;
    logic [15:0] pc_in;
    logic [7:0]  status_in, sp_in, data_in;
    logic [15:0] addr, pc_out;
    logic [7:0]  dout, sp_out;
    logic        rw, bus_oe, seq_active, halted, pc_load, sp_load, set_i;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cpu_irq_sequencer dut (
        .clk(clk), .arst_n(arst_n), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .rdy(rdy), .insn_done(insn_done), .i_flag(i_flag), .pc_in(pc_in),
        .status_in(status_in), .sp_in(sp_in), .data_in(data_in), .addr(addr),
        .dout(dout), .rw(rw), .bus_oe(bus_oe), .seq_active(seq_active),
        .halted(halted), .pc_out(pc_out), .pc_load(pc_load), .sp_out(sp_out),
        .sp_load(sp_load), .set_i(set_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ctx(input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp);
        pc_in = pc; status_in = st; sp_in = sp;
    endtask

    // Called at the falling edge right after the edge that entered DUMMY1.
    // src: 0 = maskable, 1 = non-maskable, 2 = reset
    task automatic run_sequence(input int src, input logic [6:0] stall,
                                input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp);
        logic [15:0] vb;
        logic [7:0]  lo, hi;
        vb = (src == 1) ? 16'hFFFA : (src == 2) ? 16'hFFFC : 16'hFFFE;
        lo = pc[7:0] ^ 8'hA5;
        hi = pc[15:8] ^ 8'h3C;
        for (int k = 0; k < 7; k++) begin
            logic [15:0] ea;
            logic        erw;
            logic [7:0]  ed;
            ed  = 8'h00;
            erw = 1'b1;
            case (k)
                0, 1: ea = pc;
                2: begin ea = {8'h01, sp};             erw = (src == 2); ed = pc[15:8]; end
                3: begin ea = {8'h01, 8'(sp - 8'd1)};  erw = (src == 2); ed = pc[7:0];  end
                4: begin ea = {8'h01, 8'(sp - 8'd2)};  erw = (src == 2); ed = st;       end
                5: ea = vb;
                default: ea = vb + 16'd1;
            endcase
            rdy     = ~stall[k];
            data_in = (k == 5) ? lo : (k == 6) ? hi : 8'h00;
            if (stall[k] && erw) begin
                #1;
                chk(addr == ea, "R8", "read address while stalled", 32'(addr), 32'(ea));
                if (k == 6) chk(pc_load == 1'b0, "R8", "no load while stalled", 32'(pc_load), 32'd0);
                tick();
                rdy = 1'b1;
            end
            #1;
            chk(addr == ea, (src == 2) ? "R7" : "R9", "cycle address", 32'(addr), 32'(ea));
            chk(rw == erw, (src == 2) ? "R7" : "R9", "cycle direction", 32'(rw), 32'(erw));
            chk(bus_oe && seq_active, "R1", "bus owned during entry", 32'({bus_oe, seq_active}), 32'd3);
            if (!erw) chk(dout == ed, "R9", "pushed byte", 32'(dout), 32'(ed));
            if (k == 6) begin
                chk(pc_load && sp_load && set_i, "R9", "load strobes", 32'({pc_load, sp_load, set_i}), 32'd7);
                chk(pc_out == {hi, lo}, "R1", "new program counter", 32'(pc_out), 32'({hi, lo}));
                chk(sp_out == 8'(sp - 8'd3), (src == 2) ? "R7" : "R9", "new stack pointer",
                    32'(sp_out), 32'(8'(sp - 8'd3)));
            end
            tick();
            rdy = 1'b1;
        end
        #1;
        chk(!seq_active, "R1", "idle after seventh cycle", 32'(seq_active), 32'd0);
    endtask

    task automatic trig_irq();
        i_flag = 1'b0; irq_n = 1'b0; insn_done = 1'b1;
        tick();
        insn_done = 1'b0; irq_n = 1'b1; i_flag = 1'b1;
    endtask

    task automatic trig_nmi();
        nmi_n = 1'b0;
        tick();
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
    endtask

    task automatic trig_reset();
        res_n = 1'b0;
        tick();
        #1 chk(bus_oe == 1'b1, "R6", "bus kept during grace", 32'(bus_oe), 32'd1);
        tick();
        #1 chk(!bus_oe && halted, "R6", "float after grace", 32'({bus_oe, halted}), 32'd1);
        tick();
        res_n = 1'b1;
        tick();
    endtask

    task automatic sweep();
        for (int src = 0; src < 3; src++) begin
            for (int m = 0; m < 128; m++) begin
                logic [15:0] pc;
                logic [7:0]  st, sp;
                pc = 16'(16'h1234 + m * 97 + src * 7001);
                st = 8'(m) ^ 8'h5C;
                sp = 8'(m * 37);
                set_ctx(pc, st, sp);
                if (src == 0) trig_irq();
                else if (src == 1) trig_nmi();
                else trig_reset();
                run_sequence(src, 7'(m), pc, st, sp);
                nmi_n = 1'b1;
                tick();
                tick();
            end
        end
    endtask

    task automatic directed();
        // R3 masked by interrupt-disable flag
        irq_n = 1'b0; i_flag = 1'b1; insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        #1 chk(!seq_active, "R3", "masked request ignored", 32'(seq_active), 32'd0);
        // R2 no entry without boundary
        i_flag = 1'b0;
        tick(); tick(); tick();
        #1 chk(!seq_active, "R2", "waits for boundary", 32'(seq_active), 32'd0);
        // R3 level request repeats
        set_ctx(16'h4000, 8'h21, 8'hF0);
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        run_sequence(0, 7'd0, 16'h4000, 8'h21, 8'hF0);
        set_ctx(16'h8123, 8'h22, 8'hED);
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        run_sequence(0, 7'd0, 16'h8123, 8'h22, 8'hED);
        irq_n = 1'b1;
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        #1 chk(!seq_active, "R3", "released request ignored", 32'(seq_active), 32'd0);
        i_flag = 1'b1;
        // R4 one entry per assertion
        set_ctx(16'h2222, 8'h01, 8'h80);
        trig_nmi();
        run_sequence(1, 7'd0, 16'h2222, 8'h01, 8'h80);
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        #1 chk(!seq_active, "R4", "held line gives no second entry", 32'(seq_active), 32'd0);
        nmi_n = 1'b1; tick(); nmi_n = 1'b0; tick();
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        #1 chk(!seq_active, "R4", "one high sample does not re-arm", 32'(seq_active), 32'd0);
        nmi_n = 1'b1; tick(); tick();
        set_ctx(16'h3333, 8'h02, 8'h7F);
        trig_nmi();
        run_sequence(1, 7'd0, 16'h3333, 8'h02, 8'h7F);
        // R5 priority
        nmi_n = 1'b1; tick(); tick();
        set_ctx(16'h5555, 8'h03, 8'h40);
        nmi_n = 1'b0; tick();
        irq_n = 1'b0; i_flag = 1'b0; insn_done = 1'b1; tick(); insn_done = 1'b0;
        run_sequence(1, 7'd0, 16'h5555, 8'h03, 8'h40);
        set_ctx(16'h6666, 8'h04, 8'h3D);
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        run_sequence(0, 7'd0, 16'h6666, 8'h04, 8'h3D);
        irq_n = 1'b1; i_flag = 1'b1; nmi_n = 1'b1;
        tick(); tick();
    endtask

    initial begin
        arst_n = 1'b0; res_n = 1'b0; nmi_n = 1'b1; irq_n = 1'b1; rdy = 1'b1;
        insn_done = 1'b0; i_flag = 1'b1; data_in = 8'h00;
        set_ctx(16'h0000, 8'h00, 8'h00);
        tick(); tick(); tick();
        arst_n = 1'b1;
        #1 chk(halted && !bus_oe, "R10", "power-on park", 32'({halted, bus_oe}), 32'd2);
        tick();
        #1 chk(halted && !bus_oe, "R10", "still parked", 32'({halted, bus_oe}), 32'd2);
        set_ctx(16'hC000, 8'h34, 8'h00);
        res_n = 1'b1;
        tick();
        run_sequence(2, 7'd0, 16'hC000, 8'h34, 8'h00);
        tick(); tick();
        sweep();
        directed();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule